// File: doc/BRIEF.md
# Accumulating Correlation Memory Controller

This block receives digitised pixel samples for one phase step of a correlation measurement and stores them in an on-chip word memory. Each stored word is eight bits wider than a sample. The address is built from the phase-step index and the pixel number. Before a sample is stored, a configurable number of consecutive readings (one to six) can be averaged to suppress read-out noise.

A measurement run is a programmed number of passes over the pixel array. Each pass stores one correlation point per pixel and phase. On the first pass, each word is overwritten with the zero-extended value. On every later pass, the value is added to the word already held. The sum is kept undivided, which preserves the extra resolution gained. One pass-end strobe per pass advances the pass counter, and a done flag rises once the programmed number of passes has finished.

A separate read port lets a later upload engine fetch words. The input is assumed to come from a clock-crossing FIFO already in this clock domain.

Top module: `corr_accum_mem`

## Requirements
- R1: After reset, `run_done` is 0.
- R2: During the first pass of a run, a stored result is written as the 12-bit value with the upper 8 bits of the 20-bit word equal to zero. Any earlier content is replaced.
- R3: During the second and later passes of a run, the result is added to the word already at its address, with no division.
- R4: A result is stored at word address `phase * 2**PIX_W + pixel`, i.e. `{phase, pixel}`. The phase and pixel are those presented with the last sample of its averaging group.
- R5: With `cfg_avg_n` = n, each group of n consecutive accepted samples yields one result equal to floor(sum / n). A value of 0 acts as 1, and values above 6 act as 6.
- R6: 256 accumulated full-scale results (4095) on one word read back as 1048320, with no wrap.
- R7: Results for the same address on consecutive cycles all contribute to the stored sum.
- R8: `run_done` rises on the `pass_end` that completes `cfg_passes_m1 + 1` passes. It stays 0 before that, and `run_start` clears it and the pass count.
- R9: `rd_data` presents the word at `rd_addr` one cycle after `rd_en`, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_start | input | 1 | Begin a run: clears pass count, done flag and averaging group |
| pass_end | input | 1 | Strobe after the last sample of a pass |
| cfg_passes_m1 | input | PASS_W | Number of passes in the run minus one |
| cfg_avg_n | input | CNT_W | Samples averaged per stored result |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | SAMPLE_W | Digitised pixel value |
| in_pixel | input | PIX_W | Pixel number of the sample |
| in_phase | input | PHASE_W | Phase-step index of the sample |
| rd_en | input | 1 | Read request |
| rd_addr | input | PIX_W+PHASE_W | Word address to read |
| rd_data | output | WORD_W | Read word, one cycle after the request |
| run_done | output | 1 | All programmed passes finished |

## Verification
The hardest case to reach is a read-modify-write that follows another write to the same word in the very next cycle. The memory still holds the stale value then, so the correct sum depends on forwarding. That happens only with single-sample groups, during an accumulating pass, with valid held high across several cycles on one address. The stimulus builds exactly that burst and mixes it with an interleaved pattern at distance two. The overflow margin is reached by 256 passes of full-scale input on one word.

// File: rtl/corr_accum_mem.sv
module corr_accum_mem #(
  parameter int SAMPLE_W = 12,
  parameter int WORD_W   = 20,
  parameter int PIX_W    = 6,
  parameter int PHASE_W  = 4,
  parameter int PASS_W   = 8,
  parameter int AVG_MAX  = 6,
  parameter int CNT_W    = $clog2(AVG_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run_start,
  input  logic                       pass_end,
  input  logic [PASS_W-1:0]          cfg_passes_m1,
  input  logic [CNT_W-1:0]           cfg_avg_n,
  input  logic                       in_valid,
  input  logic [SAMPLE_W-1:0]        in_sample,
  input  logic [PIX_W-1:0]           in_pixel,
  input  logic [PHASE_W-1:0]         in_phase,
  input  logic                       rd_en,
  input  logic [PIX_W+PHASE_W-1:0]   rd_addr,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       run_done
);

  localparam int ADDR_W = PIX_W + PHASE_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int SUM_W  = SAMPLE_W + $clog2(AVG_MAX);

  logic [WORD_W-1:0] mem [DEPTH];

  // pass bookkeeping
  logic [PASS_W:0] pass_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || run_start) begin
      pass_cnt <= '0;
      run_done <= 1'b0;
    end else if (pass_end) begin
      pass_cnt <= pass_cnt + 1'b1;
      if (pass_cnt == {1'b0, cfg_passes_m1}) run_done <= 1'b1;
    end
  end

  // pre-averaging stage
  logic [CNT_W-1:0]    n_eff, grp_cnt;
  logic [SUM_W-1:0]    grp_sum, sum_next;
  logic [SAMPLE_W-1:0] avg_val;
  logic                grp_last;

  assign n_eff    = (cfg_avg_n == '0) ? CNT_W'(1) :
                    (cfg_avg_n > CNT_W'(AVG_MAX)) ? CNT_W'(AVG_MAX) : cfg_avg_n;
  assign sum_next = grp_sum + SUM_W'(in_sample);
  assign grp_last = in_valid && (grp_cnt + CNT_W'(1) >= n_eff);
  assign avg_val  = SAMPLE_W'(sum_next / SUM_W'(n_eff));

  always_ff @(posedge clk) begin
    if (!rst_n || run_start) begin
      grp_cnt <= '0;
      grp_sum <= '0;
    end else if (in_valid) begin
      if (grp_last) begin
        grp_cnt <= '0;
        grp_sum <= '0;
      end else begin
        grp_cnt <= grp_cnt + CNT_W'(1);
        grp_sum <= sum_next;
      end
    end
  end

  // stage 1: result waiting for its memory read
  logic                s1_valid, s1_acc;
  logic [ADDR_W-1:0]   s1_addr;
  logic [SAMPLE_W-1:0] s1_val;

  always_ff @(posedge clk) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= grp_last;
  end

  always_ff @(posedge clk) begin
    if (grp_last) begin
      s1_addr <= {in_phase, in_pixel};
      s1_val  <= avg_val;
      s1_acc  <= (pass_cnt != '0);
    end
  end

  // stage 2: combine with old word and write
  logic                s2_valid, s2_acc, fwd;
  logic [ADDR_W-1:0]   s2_addr;
  logic [SAMPLE_W-1:0] s2_val;
  logic [WORD_W-1:0]   s2_old, s2_wdata;

  assign fwd      = s2_valid && (s2_addr == s1_addr);
  assign s2_wdata = s2_acc ? s2_old + WORD_W'(s2_val) : WORD_W'(s2_val);

  always_ff @(posedge clk) begin
    if (!rst_n) s2_valid <= 1'b0;
    else        s2_valid <= s1_valid;
  end

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      s2_addr <= s1_addr;
      s2_val  <= s1_val;
      s2_acc  <= s1_acc;
      s2_old  <= fwd ? s2_wdata : mem[s1_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (s2_valid) mem[s2_addr] <= s2_wdata;
  end

  // upload read port
  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

  // checks
  p_zero_ext_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_acc) |=> (mem[$past(s2_addr)][WORD_W-1:SAMPLE_W] == '0));

  p_forward_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s2_valid && s1_addr == s2_addr) |=> (s2_old == $past(s2_wdata)));

  p_grp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grp_cnt < CNT_W'(AVG_MAX));

  p_done_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_done) |-> $past(pass_end));

  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run_start |=> !run_done);

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sim_corr_accum_mem.sv
`timescale 1ns/1ps
module sim_corr_accum_mem;
  localparam int PIX_W = 6, PHASE_W = 4, AW = PIX_W + PHASE_W, N = 1 << AW;

  logic clk = 0, rst_n = 0, run_start = 0, pass_end = 0, in_valid = 0, rd_en = 0;
  logic [7:0]  cfg_passes_m1 = 0;
  logic [2:0]  cfg_avg_n = 1;
  logic [11:0] in_sample = 0;
  logic [PIX_W-1:0]   in_pixel = 0;
  logic [PHASE_W-1:0] in_phase = 0;
  logic [AW-1:0] rd_addr = 0;
  logic [19:0] rd_data;
  logic run_done;

  int total = 0, fails = 0;
  int expm [N];
  int pass_no = 0;

  always #2 clk = ~clk;

  corr_accum_mem u0 (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .pass_end(pass_end),
    .cfg_passes_m1(cfg_passes_m1), .cfg_avg_n(cfg_avg_n), .in_valid(in_valid),
    .in_sample(in_sample), .in_pixel(in_pixel), .in_phase(in_phase),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .run_done(run_done));

  function automatic int eff_n(int n);
    if (n == 0) return 1;
    if (n > 6) return 6;
    return n;
  endfunction

  function automatic void model_store(int a, int v);
    if (pass_no == 0) expm[a] = v;
    else expm[a] = expm[a] + v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start(int passes_m1, int avg);
    cfg_passes_m1 = 8'(passes_m1);
    cfg_avg_n = 3'(avg);
    run_start = 1;
    @(negedge clk);
    run_start = 0;
    pass_no = 0;
  endtask

  task automatic put(int v, int a);
    in_valid = 1;
    in_sample = 12'(v);
    in_pixel = PIX_W'(a % (1 << PIX_W));
    in_phase = PHASE_W'(a >> PIX_W);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 0;
    @(negedge clk);
  endtask

  task automatic end_pass();
    in_valid = 0;
    pass_end = 1;
    @(negedge clk);
    pass_end = 0;
    pass_no++;
  endtask

  task automatic rd(int a, output int d);
    repeat (4) @(negedge clk);
    rd_en = 1;
    rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 0;
    d = int'(rd_data);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    finish_up();
  end

  initial begin
    int d, a, v, sum, n;
    int addrs [8];
    void'($urandom(32'd17));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(run_done == 1'b0, "R1", int'(run_done), 0);

    // single pass overwrite with zero extension
    start(0, 1);
    for (int i = 0; i < 20; i++) begin
      a = int'($urandom % N);
      v = int'($urandom % 4096);
      put(v, a);
      model_store(a, v);
      addrs[i % 8] = a;
    end
    put(4095, 3 * 64 + 5);
    model_store(3 * 64 + 5, 4095);
    end_pass();
    chk(run_done == 1'b1, "R8", int'(run_done), 1);
    for (int i = 0; i < 8; i++) begin
      rd(addrs[i], d);
      chk(d == expm[addrs[i]], "R2", d, expm[addrs[i]]);
    end
    rd(3 * 64 + 5, d);
    chk(d == 4095, "R4", d, 4095);

    // three passes, accumulate after the first
    start(2, 1);
    chk(run_done == 1'b0, "R8", int'(run_done), 0);
    for (int i = 0; i < 8; i++) addrs[i] = 100 + i * 37;
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < 12; i++) begin
        v = int'($urandom % 4096);
        put(v, addrs[i % 8]);
        model_store(addrs[i % 8], v);
        if ($urandom % 2 == 0) idle();
      end
      end_pass();
      chk(run_done == (p == 2), "R8", int'(run_done), int'(p == 2));
    end
    for (int i = 0; i < 8; i++) begin
      rd(addrs[i], d);
      chk(d == expm[addrs[i]], "R3", d, expm[addrs[i]]);
    end

    // pre-averaging with every setting including clamped ones
    start(0, 1);
    for (int t = 0; t < 24; t++) begin
      cfg_avg_n = 3'(t % 8);
      n = eff_n(t % 8);
      sum = 0;
      a = 500 + t;
      for (int k = 0; k < n; k++) begin
        v = (t == 6) ? 4095 : int'($urandom % 4096);
        sum += v;
        put(v, (k == n - 1) ? a : a + 200);
      end
      if ($urandom % 2 == 0) idle();
      model_store(a, sum / n);
    end
    in_valid = 0;
    for (int t = 0; t < 24; t++) begin
      rd(500 + t, d);
      chk(d == expm[500 + t], "R5", d, expm[500 + t]);
    end

    // back-to-back accumulation on one word
    start(1, 1);
    put(1000, 77);
    model_store(77, 1000);
    end_pass();
    for (int i = 0; i < 5; i++) begin
      v = int'($urandom % 4096);
      put(v, 77);
      model_store(77, v);
    end
    put(11, 78); model_store(78, 11);
    put(22, 77); model_store(77, 22);
    put(33, 78); model_store(78, 33);
    put(44, 77); model_store(77, 44);
    end_pass();
    rd(77, d);
    chk(d == expm[77], "R7", d, expm[77]);

    // overflow margin
    start(255, 1);
    for (int p = 0; p < 256; p++) begin
      put(4095, 900);
      if (p == 255) chk(run_done == 1'b0, "R8", int'(run_done), 0);
      end_pass();
    end
    chk(run_done == 1'b1, "R8", int'(run_done), 1);
    rd(900, d);
    chk(d == 1048320, "R6", d, 1048320);
    start(0, 1);
    chk(run_done == 1'b0, "R8", int'(run_done), 0);

    // read port holds while idle
    rd(77, d);
    put(5, 77);
    idle();
    repeat (4) @(negedge clk);
    chk(int'(rd_data) == d, "R9", int'(rd_data), d);
    rd(77, d);
    chk(d == 5, "R9", d, 5);

    finish_up();
  end
endmodule